// File: doc/BRIEF.md
# Shift Unit with Carry and Extend Flags

This block shifts a 32-bit operand left, logically right or arithmetically right by a count taken from a register, and reports the last bit shifted out as a carry flag plus a copy of it as an extend flag. A caller raises a start strobe for one clock with the operand, the count, the shift kind and the carry flag it currently holds. The result and both flags appear on registered outputs one clock later, together with a one-cycle done pulse.

The count is used modulo twice the data width, 64 at the default width. So counts from 33 to 63 are real shifts that empty the word, and a count of exactly 32 still produces a carry from the operand's edge bit. A count of zero moves no bit, so the previous carry passes through unchanged.

Top module: `shf_unit`

## Requirements
- R1: Only the low 6 bits of `amt_in` are used. A count of 64+k behaves exactly as a count of k.
- R2: When the used count is zero, `result_out` equals `value_in` and `carry_out` equals `carry_in`.
- R3: With `kind_in` = 2'b00 (left shift) and a count n in 1..31, the result is the operand shifted left by n with zeros entering, and the carry is operand bit 32-n.
- R4: With `kind_in` = 2'b01 (logical right shift) and a count n in 1..31, the result is the operand shifted right by n with zeros entering, and the carry is operand bit n-1.
- R5: A count of exactly 32 gives a zero result for both logical shifts. The carry is operand bit 0 for the left shift and operand bit 31 for the logical right shift.
- R6: A logical shift, left or right, with a count from 33 to 63 gives a zero result and a zero carry.
- R7: With `kind_in` = 2'b10 (arithmetic right shift), counts 1..31 copy the sign bit into the vacated positions and the carry is operand bit n-1. Counts of 32 or more make every result bit equal to the sign bit, and the carry equals the sign bit.
- R8: `extend_out` equals `carry_out` after every operation.
- R9: `kind_in` = 2'b11 is reserved. It returns the operand unchanged and passes `carry_in` to the carry, for any count.
- R10: Result and flags update on the clock edge that samples `start`. `done_out` is high for exactly the cycle after a start. Without a start, the outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle operation strobe |
| value_in | input | 32 | Operand |
| amt_in | input | 8 | Shift count; low 6 bits used |
| kind_in | input | 2 | Shift kind: 00 left, 01 logical right, 10 arithmetic right, 11 reserved |
| carry_in | input | 1 | Carry flag held before the operation |
| result_out | output | 32 | Shifted value |
| carry_out | output | 1 | Last bit shifted out |
| extend_out | output | 1 | Copy of the carry |
| done_out | output | 1 | High the cycle after a start |

## Verification
The bench targets the count boundaries 0, 1, 31, 32, 33 and 63, plus counts above 63.

- A design that masks to 5 bits would treat 32 as 0 and return the operand.
- A design with an off-by-one carry index would report the wrong edge bit at 1 and 31.
- A design that treats 32 like the counts above it would clear the carry that R5 keeps.
- A design that clears the carry on a zero count, or on the reserved kind, would lose the prior flag.
- A design that zero-fills arithmetic shifts of 32 or more would fail on negative operands.

// File: rtl/shf_pkg.sv
package shf_pkg;
   typedef enum logic [1:0] {
      SHK_LEFT = 2'b00,
      SHK_LSR  = 2'b01,
      SHK_ASR  = 2'b10,
      SHK_RSV  = 2'b11
   } shf_kind_e;

   function automatic logic [63:0] bit_rev64(input logic [63:0] x, input int unsigned w);
      logic [63:0] r;
      r = '0;
      for (int i = 0; i < 64; i++)
         if (i < int'(w)) r[w - 1 - i] = x[i];
      return r;
   endfunction
endpackage

// File: rtl/shf_count_dec.sv
module shf_count_dec
   import shf_pkg::*;
#(
   parameter int AMT_IN_W = 8,
   parameter int CNT_W    = 6
) (
   input  logic [AMT_IN_W-1:0] amt,
   input  logic [1:0]          kind,
   output logic [CNT_W-1:0]    cnt,
   output logic                keep,
   output logic                to_left,
   output logic                sign_fill
);
   if (AMT_IN_W < CNT_W) begin : g_bad_amt
      $error("shf_count_dec: AMT_IN_W must cover CNT_W");
   end

   always_comb begin
      cnt       = amt[CNT_W-1:0];
      keep      = (cnt == '0) || (kind == SHK_RSV);
      to_left   = (kind == SHK_LEFT);
      sign_fill = (kind == SHK_ASR);
   end
endmodule

// File: rtl/shf_barrel.sv
module shf_barrel #(
   parameter int W1         = 33,
   parameter int CNT_W      = 6,
   parameter bit LOG_STAGES = 1'b1
) (
   input  logic [W1-1:0]    word_in,
   input  logic [CNT_W-1:0] cnt,
   input  logic             fill,
   output logic [W1-1:0]    word_out
);
   if (LOG_STAGES) begin : g_stages
      logic [W1-1:0] stg [0:CNT_W];
      assign stg[0] = word_in;
      for (genvar k = 0; k < CNT_W; k++) begin : g_stage
         localparam int SH = 1 << k;
         logic [W1-1:0] moved;
         if (SH >= W1) begin : g_all
            assign moved = {W1{fill}};
         end else begin : g_part
            assign moved = {{SH{fill}}, stg[k][W1-1:SH]};
         end
         assign stg[k+1] = cnt[k] ? moved : stg[k];
      end
      assign word_out = stg[CNT_W];
   end else begin : g_operator
      always_comb begin
         if (fill) word_out = ~((~word_in) >> cnt);
         else      word_out = word_in >> cnt;
      end
   end
endmodule

// File: rtl/shf_flag_sel.sv
module shf_flag_sel
   import shf_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W:0]   shifted,
   input  logic [DATA_W-1:0] value,
   input  logic              keep,
   input  logic              to_left,
   input  logic              carry_prev,
   output logic [DATA_W-1:0] result,
   output logic              carry
);
   logic [DATA_W-1:0] upper;
   logic [63:0]       upper_rev;

   always_comb begin
      upper     = shifted[DATA_W:1];
      upper_rev = bit_rev64(64'(upper), DATA_W);
      if (keep) begin
         result = value;
         carry  = carry_prev;
      end else begin
         result = to_left ? upper_rev[DATA_W-1:0] : upper;
         carry  = shifted[0];
      end
   end
endmodule

// File: rtl/shf_unit.sv
module shf_unit
   import shf_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int AMT_IN_W   = 8,
   parameter bit LOG_STAGES = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [DATA_W-1:0]   value_in,
   input  logic [AMT_IN_W-1:0] amt_in,
   input  logic [1:0]          kind_in,
   input  logic                carry_in,
   output logic [DATA_W-1:0]   result_out,
   output logic                carry_out,
   output logic                extend_out,
   output logic                done_out
);
   localparam int CNT_W = $clog2(DATA_W) + 1;
   localparam int W1    = DATA_W + 1;

   if (DATA_W < 2 || DATA_W > 63 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_w
      $error("shf_unit: DATA_W must be a power of two from 2 to 32");
   end

   logic [CNT_W-1:0]  cnt;
   logic              keep, to_left, sign_fill;
   logic [W1-1:0]     word_in, word_shifted;
   logic [63:0]       val_rev;
   logic [DATA_W-1:0] res_n;
   logic              carry_n;

   shf_count_dec #(.AMT_IN_W(AMT_IN_W), .CNT_W(CNT_W)) u_dec (
      .amt(amt_in), .kind(kind_in), .cnt(cnt), .keep(keep),
      .to_left(to_left), .sign_fill(sign_fill)
   );

   // left shifts run through the right shifter on a bit-reversed word
   always_comb begin
      val_rev = bit_rev64(64'(value_in), DATA_W);
      word_in = to_left ? {val_rev[DATA_W-1:0], 1'b0} : {value_in, 1'b0};
   end

   shf_barrel #(.W1(W1), .CNT_W(CNT_W), .LOG_STAGES(LOG_STAGES)) u_bar (
      .word_in(word_in), .cnt(cnt), .fill(sign_fill & value_in[DATA_W-1]),
      .word_out(word_shifted)
   );

   shf_flag_sel #(.DATA_W(DATA_W)) u_sel (
      .shifted(word_shifted), .value(value_in), .keep(keep), .to_left(to_left),
      .carry_prev(carry_in), .result(res_n), .carry(carry_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_out <= '0;
         carry_out  <= 1'b0;
         extend_out <= 1'b0;
         done_out   <= 1'b0;
      end else begin
         done_out <= start;
         if (start) begin
            result_out <= res_n;
            carry_out  <= carry_n;
            extend_out <= carry_n;
         end
      end
   end

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> done_out);
   assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !done_out);
   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> ($stable(result_out) && $stable(carry_out)));
   assert_ext_eq_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_out |-> (extend_out == carry_out));
   assert_zero_cnt_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (done_out && $past(amt_in[CNT_W-1:0]) == '0)
         |-> (result_out == $past(value_in) && carry_out == $past(carry_in)));
   assert_big_logic_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_out && ($past(kind_in) == SHK_LEFT || $past(kind_in) == SHK_LSR)
         && $past(amt_in[CNT_W-1:0]) > CNT_W'(DATA_W))
         |-> (result_out == '0 && !carry_out));
   assert_asr_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_out && $past(kind_in) == SHK_ASR && $past(amt_in[CNT_W-1:0]) >= CNT_W'(DATA_W))
         |-> (result_out == {DATA_W{$past(value_in[DATA_W-1])}}
              && carry_out == $past(value_in[DATA_W-1])));
   assert_rsv_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_out && $past(kind_in) == SHK_RSV)
         |-> (result_out == $past(value_in) && carry_out == $past(carry_in)));
endmodule

// File: tb/sim_shf_unit.sv
`timescale 1ns/1ps
module sim_shf_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] value_in = '0;
   logic [7:0]  amt_in = '0;
   logic [1:0]  kind_in = '0;
   logic        carry_in = 1'b0;
   logic [31:0] result_out;
   logic        carry_out, extend_out, done_out;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   shf_unit u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .value_in(value_in),
      .amt_in(amt_in), .kind_in(kind_in), .carry_in(carry_in),
      .result_out(result_out), .carry_out(carry_out),
      .extend_out(extend_out), .done_out(done_out)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // model written from the requirement text
   task automatic model(input logic [31:0] v, input logic [7:0] a, input logic [1:0] k,
                        input logic ci, output logic [31:0] r, output logic c);
      int n;
      n = int'(a) % 64;
      if (k == 2'b11 || n == 0) begin
         r = v; c = ci;
      end else if (k == 2'b00) begin
         r = (n >= 32) ? 32'h0 : (v << n);
         c = (n <= 32) ? v[32 - n] : 1'b0;
      end else if (k == 2'b01) begin
         r = (n >= 32) ? 32'h0 : (v >> n);
         c = (n <= 32) ? v[n - 1] : 1'b0;
      end else begin
         if (n >= 32) begin
            r = {32{v[31]}}; c = v[31];
         end else begin
            r = 32'($signed(v) >>> n); c = v[n - 1];
         end
      end
   endtask

   task automatic run_op(input string req, input logic [31:0] v, input logic [7:0] a,
                         input logic [1:0] k, input logic ci);
      logic [31:0] er;
      logic ec;
      model(v, a, k, ci, er, ec);
      @(negedge clk);
      value_in = v; amt_in = a; kind_in = k; carry_in = ci; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      value_in = ~v; carry_in = ~ci;
      chk(req, "result", result_out, er);
      chk(req, "carry", 32'(carry_out), 32'(ec));
      chk("R8", "extend", 32'(extend_out), 32'(ec));
      chk("R10", "done", 32'(done_out), 32'd1);
   endtask

   task automatic test_reset();
      chk("R10", "reset result", result_out, 32'h0);
      chk("R10", "reset carry", 32'(carry_out), 32'd0);
      chk("R10", "reset done", 32'(done_out), 32'd0);
   endtask

   task automatic test_zero_count_R2();
      run_op("R2", 32'hDEAD_BEEF, 8'd0, 2'b00, 1'b1);
      run_op("R2", 32'h1234_5678, 8'd0, 2'b01, 1'b0);
      run_op("R2", 32'h8000_0001, 8'd0, 2'b10, 1'b1);
   endtask

   task automatic test_left_R3();
      run_op("R3", 32'h8000_0001, 8'd1, 2'b00, 1'b0);
      run_op("R3", 32'h0000_0003, 8'd31, 2'b00, 1'b0);
      run_op("R3", 32'hF0F0_1234, 8'd4, 2'b00, 1'b0);
      run_op("R3", 32'h0F00_0000, 8'd5, 2'b00, 1'b1);
   endtask

   task automatic test_lsr_R4();
      run_op("R4", 32'h0000_0001, 8'd1, 2'b01, 1'b0);
      run_op("R4", 32'hC000_0000, 8'd31, 2'b01, 1'b0);
      run_op("R4", 32'h8765_4321, 8'd12, 2'b01, 1'b1);
   endtask

   task automatic test_exact32_R5();
      run_op("R5", 32'h0000_0001, 8'd32, 2'b00, 1'b0);
      run_op("R5", 32'hFFFF_FFFE, 8'd32, 2'b00, 1'b1);
      run_op("R5", 32'h8000_0000, 8'd32, 2'b01, 1'b0);
      run_op("R5", 32'h7FFF_FFFF, 8'd32, 2'b01, 1'b1);
   endtask

   task automatic test_large_R6();
      run_op("R6", 32'hFFFF_FFFF, 8'd33, 2'b00, 1'b1);
      run_op("R6", 32'hFFFF_FFFF, 8'd63, 2'b01, 1'b1);
      run_op("R6", 32'hFFFF_FFFF, 8'd40, 2'b00, 1'b1);
   endtask

   task automatic test_asr_R7();
      run_op("R7", 32'h8000_0010, 8'd4, 2'b10, 1'b0);
      run_op("R7", 32'h4000_0001, 8'd1, 2'b10, 1'b0);
      run_op("R7", 32'h8000_0000, 8'd32, 2'b10, 1'b0);
      run_op("R7", 32'h8000_0000, 8'd63, 2'b10, 1'b0);
      run_op("R7", 32'h7FFF_FFFF, 8'd45, 2'b10, 1'b1);
   endtask

   task automatic test_modulo_R1();
      run_op("R1", 32'h0000_00F0, 8'd68, 2'b01, 1'b0);
      run_op("R1", 32'hABCD_0123, 8'd64, 2'b00, 1'b1);
      run_op("R1", 32'h0000_0001, 8'd160, 2'b00, 1'b0);
   endtask

   task automatic test_reserved_R9();
      run_op("R9", 32'h5555_AAAA, 8'd7, 2'b11, 1'b1);
      run_op("R9", 32'hFFFF_0000, 8'd32, 2'b11, 1'b0);
   endtask

   task automatic test_timing_R10();
      logic [31:0] held_r;
      logic held_c;
      run_op("R10", 32'h0000_0100, 8'd8, 2'b00, 1'b0);
      held_r = result_out;
      held_c = carry_out;
      @(negedge clk);
      chk("R10", "done falls", 32'(done_out), 32'd0);
      value_in = 32'hFFFF_FFFF; amt_in = 8'd3; kind_in = 2'b01;
      repeat (3) @(negedge clk);
      chk("R10", "result held", result_out, held_r);
      chk("R10", "carry held", 32'(carry_out), 32'(held_c));
      chk("R10", "done idle", 32'(done_out), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      test_zero_count_R2();
      test_left_R3();
      test_lsr_R4();
      test_exact32_R5();
      test_large_R6();
      test_asr_R7();
      test_modulo_R1();
      test_reserved_R9();
      test_timing_R10();
      for (int i = 0; i < 64; i++)
         run_op("R1", 32'h9E37_79B9 ^ (32'(i) * 32'h0101_0101), 8'(i), 2'(i % 3), 1'(i % 2));
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule